// File: doc/BRIEF.md
# Address-Match Break Controller

This block is the debug break unit of a small 8-bit processor whose instruction address bus is 16 bits wide. Software loads a break address through a byte-wide register port, split into an upper byte register and a lower byte register. Each half is compared with the matching half of the program-counter address. A break needs both halves to match and the enable bit to be set. A break can also be forced by software, with no address match at all.

The break is only taken at an instruction boundary. If the match comes on an instruction's final cycle, the break starts on the next clock. If it comes earlier, the request is held and the break starts after the next final-cycle indication. During the break the block hands the core the software-interrupt opcode and a vector fetch address, and the vector address depends on monitor mode. It also tells the peripherals to stop their timer counters, and it turns the watchdog off when the test voltage is present on the reset pin. A return-from-interrupt ends the break. A separate control bit is exported unchanged as permission to clear peripheral status flags during the break.

Top module: `brk_ctrl`

## Requirements
- R1: A synchronous reset clears every register to zero. After reset `brk_active`, `brk_req`, `tmr_freeze`, `wdog_off` and `flag_clr_ok` are 0, and `swi_opcode` and `vec_addr` are 0.
- R2: Register offsets on the byte bus are: 0 is the break address upper byte, 1 is the lower byte, 2 is status, 3 is flag control. Status bit 7 is the stored enable and bit 6 reads back the break-active state. Flag control bit 0 is the stored clear permission. All other bits read 0. `bus_rdata` is combinational on `bus_addr`.
- R3: An address match needs the enable bit set, `cpu_addr[15:8]` equal to the upper byte and `cpu_addr[7:0]` equal to the lower byte. A difference in either half, or a clear enable bit, causes no break.
- R4: A match in a cycle with `cpu_last`=1 sets `brk_active` on the next clock.
- R5: A match in a cycle with `cpu_last`=0 is remembered. `brk_active` rises on the clock after the first later cycle with `cpu_last`=1, and stays 0 until then.
- R6: A write to status with bit 6 = 1 sets `brk_active` on the next clock, whatever the enable bit and the address.
- R7: While `brk_active`=1, `swi_opcode`=8'h83 and `vec_addr` is 16'hFFFC, or 16'hFEFC when `mon_mode`=1. Outside a break both outputs are 0.
- R8: `brk_req` pulses high for exactly the first cycle in which `brk_active` is 1.
- R9: `cpu_rti`=1 during a break clears `brk_active` on the next clock. `cpu_rti` outside a break has no effect.
- R10: `tmr_freeze` equals `brk_active`. `wdog_off` is `brk_active` AND `tst_volt`.
- R11: `flag_clr_ok` follows flag control bit 0.
- R12: A match or a forced break during an active break neither restarts it nor raises `brk_req` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cpu_addr | input | 16 | Program-counter address |
| cpu_last | input | 1 | Current cycle is the last cycle of an instruction |
| cpu_rti | input | 1 | Return-from-interrupt executing |
| mon_mode | input | 1 | Monitor mode selects the alternate vector |
| tst_volt | input | 1 | Test voltage present on the reset pin |
| brk_req | output | 1 | One-cycle pulse when a break starts |
| brk_active | output | 1 | Break state |
| swi_opcode | output | 8 | Opcode for the instruction register during a break |
| vec_addr | output | 16 | Vector fetch address during a break |
| tmr_freeze | output | 1 | Stop timer counters |
| wdog_off | output | 1 | Disable watchdog |
| flag_clr_ok | output | 1 | Status flags may be cleared during a break |

## Verification
The assertions assume that `cpu_last`, `cpu_rti`, `mon_mode` and the address are stable over each whole clock cycle. They also assume `cpu_rti` is only meaningful while a break is active. The stimulus changes inputs only on the falling edge and asserts `cpu_rti` once both inside and outside a break, so the ignore case is covered. The address and last-cycle inputs are driven as instruction-like sequences: mid-instruction cycles followed by a final cycle, with matches placed on both kinds of cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ACTV = 2'd2
    } brk_state_e;

    typedef struct packed {
        logic en;
        logic bcfe;
    } brk_cfg_t;

    localparam int STAT_EN_BIT  = 7;
    localparam int STAT_ACT_BIT = 6;
    localparam int FLAG_CLR_BIT = 0;

    function automatic logic [15:0] pick_vector(input logic mon,
                                                input logic [15:0] norm_v,
                                                input logic [15:0] mon_v);
        return mon ? mon_v : norm_v;
    endfunction

endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SLICE_W = 8,
    parameter int RAW     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RAW-1:0]    addr,
    input  logic [SLICE_W-1:0] wdata,
    input  logic              active,
    output logic [SLICE_W-1:0] rdata,
    output logic [ADDR_W-1:0] bp_addr,
    output brk_cfg_t          cfg,
    output logic              force_brk
);
    localparam int NSLICE   = ADDR_W / SLICE_W;
    localparam int OFS_STAT = NSLICE;
    localparam int OFS_FLAG = NSLICE + 1;

    logic [SLICE_W-1:0] slice_q [NSLICE];
    logic en_q, bcfe_q;

    genvar g;
    generate
        for (g = 0; g < NSLICE; g++) begin : g_slice
            always_ff @(posedge clk) begin
                if (rst)
                    slice_q[g] <= '0;
                else if (wr_en && addr == RAW'(NSLICE - 1 - g))
                    slice_q[g] <= wdata;
            end
            assign bp_addr[g*SLICE_W +: SLICE_W] = slice_q[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            bcfe_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == RAW'(OFS_STAT)) en_q   <= wdata[STAT_EN_BIT];
            if (addr == RAW'(OFS_FLAG)) bcfe_q <= wdata[FLAG_CLR_BIT];
        end
    end

    assign force_brk = wr_en && (addr == RAW'(OFS_STAT)) && wdata[STAT_ACT_BIT];
    assign cfg.en    = en_q;
    assign cfg.bcfe  = bcfe_q;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLICE; i++)
            if (addr == RAW'(NSLICE - 1 - i)) rdata = slice_q[i];
        if (addr == RAW'(OFS_STAT)) begin
            rdata[STAT_EN_BIT]  = en_q;
            rdata[STAT_ACT_BIT] = active;
        end
        if (addr == RAW'(OFS_FLAG))
            rdata[FLAG_CLR_BIT] = bcfe_q;
    end

endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
    parameter int ADDR_W  = 16,
    parameter int SLICE_W = 8
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] bp,
    output logic              match
);
    localparam int NSLICE = ADDR_W / SLICE_W;

    logic [NSLICE-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < NSLICE; g++) begin : g_cmp
            assign eq[g] = (pc[g*SLICE_W +: SLICE_W] == bp[g*SLICE_W +: SLICE_W]);
        end
    endgenerate

    assign match = en && (&eq);

endmodule

// File: rtl/brk_fsm.sv
module brk_fsm
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic match,
    input  logic last,
    input  logic force_brk,
    input  logic rti,
    output logic active,
    output logic req
);
    brk_state_e st_q, st_d;
    logic take, req_q;

    always_comb begin
        take = (st_q != ST_ACTV) &&
               (force_brk || (last && (match || st_q == ST_PEND)));
        st_d = st_q;
        case (st_q)
            ST_ACTV: if (rti) st_d = ST_IDLE;
            default: begin
                if (take)               st_d = ST_ACTV;
                else if (match && !last) st_d = ST_PEND;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            req_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            req_q <= take;
        end
    end

    assign active = (st_q == ST_ACTV);
    assign req    = req_q;

endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
    import brk_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          SLICE_W  = 8,
    parameter int          RAW      = 2,
    parameter logic [7:0]  SWI_OP   = 8'h83,
    parameter logic [15:0] VEC_NORM = 16'hFFFC,
    parameter logic [15:0] VEC_MON  = 16'hFEFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [RAW-1:0]    bus_addr,
    input  logic [SLICE_W-1:0] bus_wdata,
    output logic [SLICE_W-1:0] bus_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_last,
    input  logic              cpu_rti,
    input  logic              mon_mode,
    input  logic              tst_volt,
    output logic              brk_req,
    output logic              brk_active,
    output logic [7:0]        swi_opcode,
    output logic [15:0]       vec_addr,
    output logic              tmr_freeze,
    output logic              wdog_off,
    output logic              flag_clr_ok
);
    logic [ADDR_W-1:0] bp_addr;
    brk_cfg_t          cfg;
    logic              bp_en;
    logic              force_brk;
    logic              match;

    brk_regs #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W), .RAW(RAW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .active   (brk_active),
        .rdata    (bus_rdata),
        .bp_addr  (bp_addr),
        .cfg      (cfg),
        .force_brk(force_brk)
    );

    assign bp_en = cfg.en;

    brk_cmp #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W)) u_cmp (
        .en   (bp_en),
        .pc   (cpu_addr),
        .bp   (bp_addr),
        .match(match)
    );

    brk_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .match    (match),
        .last     (cpu_last),
        .force_brk(force_brk),
        .rti      (cpu_rti),
        .active   (brk_active),
        .req      (brk_req)
    );

    assign swi_opcode  = brk_active ? SWI_OP : 8'h00;
    assign vec_addr    = brk_active ? pick_vector(mon_mode, VEC_NORM, VEC_MON) : 16'h0000;
    assign tmr_freeze  = brk_active;
    assign wdog_off    = brk_active && tst_volt;
    assign flag_clr_ok = cfg.bcfe;

endmodule

// File: rtl/brk_ctrl_chk.sv
module brk_ctrl_chk #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] VEC_NORM = 16'hFFFC,
    parameter logic [15:0] VEC_MON  = 16'hFEFC
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_last,
    input logic              cpu_rti,
    input logic              mon_mode,
    input logic              tst_volt,
    input logic [ADDR_W-1:0] bp_addr,
    input logic              bp_en,
    input logic              brk_active,
    input logic              brk_req,
    input logic [15:0]       vec_addr,
    input logic              tmr_freeze,
    input logic              wdog_off
);
    p_last_match_r4: assert property (@(posedge clk) disable iff (rst)
        (bp_en && cpu_addr == bp_addr && cpu_last && !brk_active) |=> brk_active);

    p_req_in_break_r8: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> brk_active);

    p_req_on_entry_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_active) |-> brk_req);

    p_vector_r7: assert property (@(posedge clk) disable iff (rst)
        brk_active |-> vec_addr == (mon_mode ? VEC_MON : VEC_NORM));

    p_rti_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (brk_active && cpu_rti) |=> !brk_active);

    p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        tmr_freeze == brk_active);

    p_wdog_r10: assert property (@(posedge clk) disable iff (rst)
        wdog_off |-> (brk_active && tst_volt));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (brk_active && !cpu_rti) |=> (brk_active && !brk_req));

endmodule

bind brk_ctrl brk_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_NORM(VEC_NORM), .VEC_MON(VEC_MON)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_last  (cpu_last),
    .cpu_rti   (cpu_rti),
    .mon_mode  (mon_mode),
    .tst_volt  (tst_volt),
    .bp_addr   (bp_addr),
    .bp_en     (bp_en),
    .brk_active(brk_active),
    .brk_req   (brk_req),
    .vec_addr  (vec_addr),
    .tmr_freeze(tmr_freeze),
    .wdog_off  (wdog_off)
);

// File: tb/tb_brk_ctrl.sv
`timescale 1ns/1ps
module tb_brk_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] cpu_addr = '0;
    logic        cpu_last = 1'b0;
    logic        cpu_rti = 1'b0;
    logic        mon_mode = 1'b0;
    logic        tst_volt = 1'b0;
    logic        brk_req, brk_active, tmr_freeze, wdog_off, flag_clr_ok;
    logic [7:0]  swi_opcode;
    logic [15:0] vec_addr;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    brk_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_addr(cpu_addr),
        .cpu_last(cpu_last), .cpu_rti(cpu_rti), .mon_mode(mon_mode),
        .tst_volt(tst_volt), .brk_req(brk_req), .brk_active(brk_active),
        .swi_opcode(swi_opcode), .vec_addr(vec_addr), .tmr_freeze(tmr_freeze),
        .wdog_off(wdog_off), .flag_clr_ok(flag_clr_ok)
    );

    // behavioural reference state
    int m_hi, m_lo, m_en, m_bcfe, m_act, m_pend, m_req;

    always @(posedge clk) begin
        int  mt, fc, tk;
        if (rst) begin
            m_hi = 0; m_lo = 0; m_en = 0; m_bcfe = 0;
            m_act = 0; m_pend = 0; m_req = 0;
        end else begin
            mt = (m_en != 0) && (cpu_addr == 16'((m_hi << 8) | m_lo));
            fc = bus_wr && bus_addr == 2 && bus_wdata[6];
            tk = !m_act && (fc || (cpu_last && (mt || m_pend)));
            m_req = tk;
            if (m_act) begin
                if (cpu_rti) m_act = 0;
            end else if (tk) begin
                m_act = 1; m_pend = 0;
            end else if (mt && !cpu_last) begin
                m_pend = 1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: m_hi = bus_wdata;
                    2'd1: m_lo = bus_wdata;
                    2'd2: m_en = bus_wdata[7];
                    default: m_bcfe = bus_wdata[0];
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_rd();
        case (bus_addr)
            2'd0: return m_hi;
            2'd1: return m_lo;
            2'd2: return (m_en << 7) | (m_act << 6);
            default: return m_bcfe;
        endcase
    endfunction

    task automatic compare_all();
        chk("R4/R5/R6/R9 brk_active", brk_active, m_act);
        chk("R8 brk_req", brk_req, m_req);
        chk("R7 swi_opcode", swi_opcode, m_act ? 8'h83 : 0);
        chk("R7 vec_addr", vec_addr, m_act ? (mon_mode ? 16'hFEFC : 16'hFFFC) : 0);
        chk("R10 tmr_freeze", tmr_freeze, m_act);
        chk("R10 wdog_off", wdog_off, m_act && tst_volt);
        chk("R11 flag_clr_ok", flag_clr_ok, m_bcfe);
        chk("R2 bus_rdata", bus_rdata, model_rd());
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic exit_break();
        cpu_rti = 1'b1; cyc();
        cpu_rti = 1'b0;
        chk("R9 rti exits break", brk_active, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run hung (R1 sequence)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1: reset state
        chk("R1 brk_active after reset", brk_active, 0);
        chk("R1 vec_addr after reset", vec_addr, 0);
        rd_chk(2'd2, 0, "R1 status after reset");
        rd_chk(2'd0, 0, "R1 addr upper after reset");

        // R2 / R11: register programming and readback
        wr(2'd0, 8'h12);
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h80);
        wr(2'd3, 8'hFF);
        rd_chk(2'd0, 8'h12, "R2 upper byte");
        rd_chk(2'd1, 8'h34, "R2 lower byte");
        rd_chk(2'd2, 8'h80, "R2 status");
        rd_chk(2'd3, 8'h01, "R2 flag control");
        chk("R11 flag_clr_ok set", flag_clr_ok, 1);
        bus_addr = 2'd2;

        // R3: partial matches and disabled enable
        cpu_last = 1'b1;
        cpu_addr = 16'h1235; cyc();
        cpu_addr = 16'h1334; cyc();
        cyc();
        chk("R3 half mismatch no break", brk_active, 0);
        wr(2'd2, 8'h00);
        cpu_addr = 16'h1234; cyc(); cyc();
        chk("R3 disabled no break", brk_active, 0);
        cpu_addr = 16'h0000;
        wr(2'd2, 8'h80);

        // R4: match on last cycle
        cpu_addr = 16'h1234; cpu_last = 1'b1; cyc();
        chk("R4 last-cycle match breaks", brk_active, 1);
        chk("R8 request pulse", brk_req, 1);
        cpu_addr = 16'h0000; cyc();
        chk("R8 pulse one cycle", brk_req, 0);
        chk("R7 normal vector", vec_addr, 16'hFFFC);
        mon_mode = 1'b1; cyc();
        chk("R7 monitor vector", vec_addr, 16'hFEFC);
        tst_volt = 1'b1; cyc();
        chk("R10 watchdog off with test voltage", wdog_off, 1);
        // R12: retrigger during break
        cpu_addr = 16'h1234; cyc();
        wr(2'd2, 8'hC0);
        chk("R12 no new request", brk_req, 0);
        cpu_addr = 16'h0000;
        exit_break();
        tst_volt = 1'b0; mon_mode = 1'b0;
        cyc();

        // R5: mid-instruction match deferred
        cpu_last = 1'b0; cpu_addr = 16'h1234; cyc();
        cpu_addr = 16'h1235; cyc(); cyc();
        chk("R5 still waiting", brk_active, 0);
        cpu_last = 1'b1; cyc();
        chk("R5 taken at boundary", brk_active, 1);
        cpu_last = 1'b0; cyc();
        exit_break();
        cyc();

        // R6: forced break with enable clear and no match
        wr(2'd2, 8'h00);
        cpu_addr = 16'h5555;
        wr(2'd2, 8'h40);
        chk("R6 forced break", brk_active, 1);
        rd_chk(2'd2, 8'h40, "R2 status active bit");
        tst_volt = 1'b0; cyc();
        chk("R10 watchdog stays on without test voltage", wdog_off, 0);
        exit_break();

        // R9: rti outside break ignored
        cpu_rti = 1'b1; cyc(); cpu_rti = 1'b0; cyc();
        chk("R9 rti outside break no effect", brk_active, 0);
        wr(2'd3, 8'h00);
        chk("R11 flag_clr_ok cleared", flag_clr_ok, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule